// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks loads that a compiler has hoisted above stores that might alias them. Each advanced load leaves an entry holding its destination register tag, its byte address and its access size. Every later store is compared against all live entries by byte range, and any entry it touches is dropped. A check on a register tag then reports whether the entry is still present. A hit means the speculatively loaded value is still good. A miss means recovery is needed.

The table is fully associative with a parameterised entry count (32 by default). It accepts at most one command per cycle. The check result appears one cycle after the command, on a registered strobe. Checks come in clearing and non-clearing forms. A non-clearing load-check that misses installs a fresh entry, just as the reload it implies would. Free slots are filled lowest index first. Once the table is full, a round-robin pointer picks the entry to overwrite. Three free-running counters record checks executed, checks that failed and overwrites of live entries. For a load that fills a register pair, the issuer passes the tag of one register of the pair. The table stores that one tag.

Top module: `spec_load_table`

## Requirements
- R1: After reset, no entry is live, every counter and every strobe reads zero, and the first check on any tag misses.
- R2: A command with `cmd_valid` high and `cmd_op` = 0 (advanced load) creates an entry with the given tag, address and size. A later check on that tag hits, and a check on any other tag misses.
- R3: An advanced load whose tag is already live first removes the old entry. Only the new address is then tracked, and this replacement never counts as a capacity event.
- R4: `cmd_op` = 1 (store) removes every live entry whose byte range [addr, addr+bytes) overlaps the store's range. A range that only abuts an entry leaves it live. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes, and codes 4 to 7 mean 16 bytes.
- R5: `cmd_op` = 2 (clearing check) reports hit or miss and frees the matching entry on a hit, so a second clearing check on the same tag misses.
- R6: `cmd_op` = 3 (non-clearing check) reports hit or miss and changes no entry. A hit can be checked again, and a miss installs nothing.
- R7: `cmd_op` = 4 (non-clearing load-check) behaves as R6 on a hit. On a miss it also allocates an entry for the tag, address and size, as an advanced load would.
- R8: `cmd_op` = 5 removes only the entry whose tag matches `cmd_rtag`.
- R9: `cmd_op` = 6 removes every entry in a single cycle.
- R10: An allocation uses the lowest-indexed free slot. When all slots are live, it overwrites the slot named by a round-robin pointer. The pointer starts at 0 and advances by one, with wrap-around, after each such overwrite. Each overwrite pulses `ev_capacity` and increments `cnt_capacity`.
- R11: Each check command (op 2, 3 or 4) pulses `ev_check` and increments `cnt_checks`. A check that misses also pulses `ev_fail` and increments `cnt_fails`. The strobes and the counters change together, one cycle after the command.
- R12: `chk_valid` is high for exactly the one cycle that follows a check command, and `chk_hit` then carries its result. `cmd_op` = 7, or `cmd_valid` low, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (see R2 to R12) |
| cmd_rtag | input | RTAG_W | Destination register tag |
| cmd_addr | input | ADDR_W | Physical byte address |
| cmd_size | input | 3 | Access size code (see R4) |
| chk_valid | output | 1 | Check result present |
| chk_hit | output | 1 | Check found a live entry |
| ev_check | output | 1 | Strobe: a check executed |
| ev_fail | output | 1 | Strobe: a check missed |
| ev_capacity | output | 1 | Strobe: a live entry was overwritten |
| cnt_checks | output | CNT_W | Total checks executed |
| cnt_fails | output | CNT_W | Total failed checks |
| cnt_capacity | output | CNT_W | Total capacity overwrites |

## Verification
The bench aims at stores that only abut an entry on either side, and at 16-byte stores that straddle an entry. An off-by-one in the range compare would either kill an innocent entry or leave a stale one live. It reloads a live tag and then stores to the old address, which exposes a design that keeps two entries for one tag or counts a false capacity event. It fills the table, frees a slot in the middle and keeps allocating until the round-robin pointer wraps, so a wrong victim order shows up as a check hitting or missing on the wrong tag. A long random run over a small tag and address space mixes every command so that these cases collide, comparing strobes and counters against a behavioural model on every clock.

// File: rtl/slt_pkg.sv
package slt_pkg;

    typedef enum logic [2:0] {
        OP_ADV_LOAD = 3'd0,
        OP_STORE    = 3'd1,
        OP_CHK_CLR  = 3'd2,
        OP_CHK_KEEP = 3'd3,
        OP_LDCHK_NC = 3'd4,
        OP_INV_ONE  = 3'd5,
        OP_INV_ALL  = 3'd6,
        OP_RSVD     = 3'd7
    } slt_op_e;

    // Byte count for an access size code
    function automatic logic [4:0] slt_size_bytes(input logic [2:0] code);
        logic [4:0] n;
        case (code)
            3'd0:    n = 5'd1;
            3'd1:    n = 5'd2;
            3'd2:    n = 5'd4;
            3'd3:    n = 5'd8;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/slt_entry_cmp.sv
module slt_entry_cmp
    import slt_pkg::*;
#(
    parameter int RTAG_W = 7,
    parameter int ADDR_W = 32
) (
    input  logic              live,
    input  logic [RTAG_W-1:0] ent_rtag,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [2:0]        ent_size,
    input  logic [RTAG_W-1:0] req_rtag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    output logic              tag_hit,
    output logic              overlap
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] ent_lo, ent_hi, req_lo, req_hi;

    always_comb begin
        ent_lo  = {1'b0, ent_addr};
        req_lo  = {1'b0, req_addr};
        ent_hi  = ent_lo + EXT_W'(slt_size_bytes(ent_size));
        req_hi  = req_lo + EXT_W'(slt_size_bytes(req_size));
        tag_hit = live && (ent_rtag == req_rtag);
        overlap = live && (ent_lo < req_hi) && (req_lo < ent_hi);
    end

endmodule

// File: rtl/slt_alloc.sv
module slt_alloc #(
    parameter int ENTRIES = 32
) (
    input  logic [ENTRIES-1:0]         free_vec,
    input  logic [$clog2(ENTRIES)-1:0] rr_ptr,
    output logic [$clog2(ENTRIES)-1:0] slot,
    output logic                       evict,
    output logic [$clog2(ENTRIES)-1:0] rr_next
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic             found;
    logic [IDX_W-1:0] lowest;

    always_comb begin
        found  = 1'b0;
        lowest = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found  = 1'b1;
                lowest = IDX_W'(i);
            end
        end
        evict   = !found;
        slot    = found ? lowest : rr_ptr;
        rr_next = (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + IDX_W'(1);
    end

endmodule

// File: rtl/slt_stats.sv
module slt_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_check,
    input  logic             do_fail,
    input  logic             do_evict,
    output logic             ev_check,
    output logic             ev_fail,
    output logic             ev_capacity,
    output logic [CNT_W-1:0] cnt_checks,
    output logic [CNT_W-1:0] cnt_fails,
    output logic [CNT_W-1:0] cnt_capacity
);
    typedef struct packed {
        logic             ev_chk;
        logic             ev_fl;
        logic             ev_cap;
        logic [CNT_W-1:0] n_chk;
        logic [CNT_W-1:0] n_fl;
        logic [CNT_W-1:0] n_cap;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.ev_chk = do_check;
        st_d.ev_fl  = do_fail;
        st_d.ev_cap = do_evict;
        if (do_check) st_d.n_chk = st_q.n_chk + CNT_W'(1);
        if (do_fail)  st_d.n_fl  = st_q.n_fl  + CNT_W'(1);
        if (do_evict) st_d.n_cap = st_q.n_cap + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_check     = st_q.ev_chk;
    assign ev_fail      = st_q.ev_fl;
    assign ev_capacity  = st_q.ev_cap;
    assign cnt_checks   = st_q.n_chk;
    assign cnt_fails    = st_q.n_fl;
    assign cnt_capacity = st_q.n_cap;

    AST_CHECK_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ev_chk |-> st_q.n_chk == $past(st_q.n_chk) + CNT_W'(1)); // R11
    AST_FAIL_IS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ev_fl |-> st_q.ev_chk); // R11
    AST_CAP_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ev_cap |-> st_q.n_cap == $past(st_q.n_cap) + CNT_W'(1)); // R10

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
    import slt_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int RTAG_W  = 7,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [RTAG_W-1:0] cmd_rtag,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [2:0]        cmd_size,
    output logic              chk_valid,
    output logic              chk_hit,
    output logic              ev_check,
    output logic              ev_fail,
    output logic              ev_capacity,
    output logic [CNT_W-1:0]  cnt_checks,
    output logic [CNT_W-1:0]  cnt_fails,
    output logic [CNT_W-1:0]  cnt_capacity
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             live;
        logic [ENTRIES-1:0][RTAG_W-1:0] rtag;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][2:0]        size;
        logic [IDX_W-1:0]               rr;
        logic                           res_valid;
        logic                           res_hit;
    } table_t;

    table_t s_d, s_q;

    slt_op_e            op;
    logic [ENTRIES-1:0] tag_hit;
    logic [ENTRIES-1:0] overlap;
    logic               any_hit;
    logic               is_check;
    logic               want_alloc;
    logic [IDX_W-1:0]   alloc_slot;
    logic               alloc_evict;
    logic [IDX_W-1:0]   rr_next;

    assign op = slt_op_e'(cmd_op);

    // One comparator per entry: tag equality and byte-range overlap
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        slt_entry_cmp #(.RTAG_W(RTAG_W), .ADDR_W(ADDR_W)) u_cmp (
            .live     (s_q.live[g]),
            .ent_rtag (s_q.rtag[g]),
            .ent_addr (s_q.addr[g]),
            .ent_size (s_q.size[g]),
            .req_rtag (cmd_rtag),
            .req_addr (cmd_addr),
            .req_size (cmd_size),
            .tag_hit  (tag_hit[g]),
            .overlap  (overlap[g])
        );
    end

    assign any_hit  = |tag_hit;
    assign is_check = cmd_valid &&
                      (op == OP_CHK_CLR || op == OP_CHK_KEEP || op == OP_LDCHK_NC);
    assign want_alloc = cmd_valid &&
                        (op == OP_ADV_LOAD || (op == OP_LDCHK_NC && !any_hit));

    // A same-tag entry counts as free: it is removed before the write
    slt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .free_vec (~s_q.live | tag_hit),
        .rr_ptr   (s_q.rr),
        .slot     (alloc_slot),
        .evict    (alloc_evict),
        .rr_next  (rr_next)
    );

    always_comb begin
        s_d           = s_q;
        s_d.res_valid = 1'b0;
        s_d.res_hit   = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_STORE:   s_d.live = s_q.live & ~overlap;
                OP_CHK_CLR: s_d.live = s_q.live & ~tag_hit;
                OP_INV_ONE: s_d.live = s_q.live & ~tag_hit;
                OP_INV_ALL: s_d.live = '0;
                default:    ;
            endcase
        end
        if (is_check) begin
            s_d.res_valid = 1'b1;
            s_d.res_hit   = any_hit;
        end
        if (want_alloc) begin
            s_d.live                 = s_d.live & ~tag_hit;
            s_d.live[alloc_slot]     = 1'b1;
            s_d.rtag[alloc_slot]     = cmd_rtag;
            s_d.addr[alloc_slot]     = cmd_addr;
            s_d.size[alloc_slot]     = cmd_size;
            if (alloc_evict) s_d.rr  = rr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    slt_stats #(.CNT_W(CNT_W)) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .do_check     (is_check),
        .do_fail      (is_check && !any_hit),
        .do_evict     (want_alloc && alloc_evict),
        .ev_check     (ev_check),
        .ev_fail      (ev_fail),
        .ev_capacity  (ev_capacity),
        .cnt_checks   (cnt_checks),
        .cnt_fails    (cnt_fails),
        .cnt_capacity (cnt_capacity)
    );

    assign chk_valid = s_q.res_valid;
    assign chk_hit   = s_q.res_hit;

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tag_hit)); // R3
    AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_INV_ALL) |=> s_q.live == '0); // R9
    AST_CLR_FREES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_CHK_CLR && any_hit) |=>
        $countones(s_q.live) == $countones($past(s_q.live)) - 1); // R5
    AST_NC_HIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && any_hit && (op == OP_CHK_KEEP || op == OP_LDCHK_NC)) |=>
        $stable(s_q.live)); // R6
    AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_capacity |-> $past(&s_q.live)); // R10
    AST_RESULT_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> $past(cmd_valid)); // R12

endmodule

// File: tb/spec_load_table_test.sv
`timescale 1ns/1ps
module spec_load_table_test;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [6:0]  cmd_rtag = '0;
    logic [31:0] cmd_addr = '0;
    logic [2:0]  cmd_size = '0;
    logic        chk_valid, chk_hit, ev_check, ev_fail, ev_capacity;
    logic [31:0] cnt_checks, cnt_fails, cnt_capacity;

    spec_load_table uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rtag(cmd_rtag), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
        .chk_valid(chk_valid), .chk_hit(chk_hit), .ev_check(ev_check),
        .ev_fail(ev_fail), .ev_capacity(ev_capacity), .cnt_checks(cnt_checks),
        .cnt_fails(cnt_fails), .cnt_capacity(cnt_capacity)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference model
    bit     m_live[N];
    int     m_tag[N];
    longint m_lo[N];
    longint m_hi[N];
    int     m_rr = 0;
    longint e_checks = 0, e_fails = 0, e_cap = 0;
    bit     e_cv, e_hit, e_evc, e_evf, e_evcap;

    function automatic longint nbytes(int code);
        return (code >= 4) ? 16 : (longint'(1) << code);
    endfunction

    function automatic void m_alloc(int tag, longint a, int sz);
        int slot = -1;
        for (int i = 0; i < N; i++) if (m_live[i] && m_tag[i] == tag) m_live[i] = 0;
        for (int i = N - 1; i >= 0; i--) if (!m_live[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
            e_evcap = 1;
            e_cap++;
        end
        m_live[slot] = 1;
        m_tag[slot]  = tag;
        m_lo[slot]   = a;
        m_hi[slot]   = a + nbytes(sz);
    endfunction

    function automatic void m_step(bit v, int op, int tag, longint a, int sz);
        int h = -1;
        e_cv = 0; e_hit = 0; e_evc = 0; e_evf = 0; e_evcap = 0;
        if (!v) return;
        for (int i = 0; i < N; i++) if (m_live[i] && m_tag[i] == tag) h = i;
        if (op == 2 || op == 3 || op == 4) begin
            e_cv = 1; e_hit = (h >= 0); e_evc = 1; e_evf = (h < 0);
            e_checks++;
            if (h < 0) e_fails++;
        end
        case (op)
            0: m_alloc(tag, a, sz);
            1: for (int i = 0; i < N; i++)
                   if (m_live[i] && m_lo[i] < a + nbytes(sz) && a < m_hi[i]) m_live[i] = 0;
            2: if (h >= 0) m_live[h] = 0;
            4: if (h < 0) m_alloc(tag, a, sz);
            5: if (h >= 0) m_live[h] = 0;
            6: for (int i = 0; i < N; i++) m_live[i] = 0;
            default: ;
        endcase
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check("R12", "chk_valid", chk_valid, e_cv);
        if (e_cv) check(req, "chk_hit", chk_hit, e_hit);
        check("R11", "ev_check", ev_check, e_evc);
        check("R11", "ev_fail", ev_fail, e_evf);
        check("R10", "ev_capacity", ev_capacity, e_evcap);
        check("R11", "cnt_checks", cnt_checks, e_checks);
        check("R11", "cnt_fails", cnt_fails, e_fails);
        check("R10", "cnt_capacity", cnt_capacity, e_cap);
    endtask

    // Drive at the falling edge, compare at the next falling edge
    task automatic cmd(string req, bit v, int op, int tag, longint a, int sz);
        cmd_valid = v;
        cmd_op    = 3'(op);
        cmd_rtag  = 7'(tag);
        cmd_addr  = 32'(a);
        cmd_size  = 3'(sz);
        m_step(v, op, tag, a, sz);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        compare_all(req);
    endtask

    task automatic expect_hit(string req, int tag, bit hit);
        cmd(req, 1, 3, tag, 0, 0);
        check(req, "probe", chk_hit, hit);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < N; i++) m_live[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        e_cv = 0; e_hit = 0; e_evc = 0; e_evf = 0; e_evcap = 0;
        compare_all("R1");
        expect_hit("R1", 3, 0);

        cmd("R2", 1, 0, 3, 'h1000, 3);
        expect_hit("R2", 3, 1);
        expect_hit("R2", 4, 0);

        cmd("R3", 1, 0, 3, 'h2000, 2);
        cmd("R3", 1, 1, 0, 'h1000, 3);
        expect_hit("R3", 3, 1);
        cmd("R3", 1, 1, 0, 'h2002, 0);
        expect_hit("R3", 3, 0);
        check("R3", "no capacity", cnt_capacity, 0);

        cmd("R4", 1, 0, 10, 'h3000, 2);
        cmd("R4", 1, 1, 0, 'h3004, 3);
        expect_hit("R4", 10, 1);
        cmd("R4", 1, 1, 0, 'h2FFC, 2);
        expect_hit("R4", 10, 1);
        cmd("R4", 1, 1, 0, 'h2FF8, 4);
        expect_hit("R4", 10, 0);
        cmd("R4", 1, 0, 11, 'h4000, 6);
        cmd("R4", 1, 1, 0, 'h400F, 0);
        expect_hit("R4", 11, 0);
        cmd("R4", 1, 0, 12, 'h5000, 0);
        cmd("R4", 1, 1, 0, 'h5001, 0);
        expect_hit("R4", 12, 1);

        cmd("R5", 1, 0, 20, 'h6000, 3);
        cmd("R5", 1, 2, 20, 0, 0);
        check("R5", "first clear hit", chk_hit, 1);
        cmd("R5", 1, 2, 20, 0, 0);
        check("R5", "second clear miss", chk_hit, 0);

        cmd("R6", 1, 0, 21, 'h6100, 3);
        expect_hit("R6", 21, 1);
        expect_hit("R6", 21, 1);
        expect_hit("R6", 22, 0);
        expect_hit("R6", 22, 0);

        cmd("R7", 1, 4, 23, 'h7000, 2);
        check("R7", "ldchk miss", chk_hit, 0);
        expect_hit("R7", 23, 1);
        cmd("R7", 1, 1, 0, 'h7000, 0);
        expect_hit("R7", 23, 0);

        cmd("R8", 1, 0, 30, 'h8000, 3);
        cmd("R8", 1, 0, 31, 'h8100, 3);
        cmd("R8", 1, 5, 30, 0, 0);
        expect_hit("R8", 30, 0);
        expect_hit("R8", 31, 1);

        cmd("R12", 1, 7, 31, 'h8100, 3);
        cmd("R12", 0, 6, 31, 0, 0);
        expect_hit("R12", 31, 1);

        cmd("R9", 1, 6, 0, 0, 0);
        expect_hit("R9", 31, 0);
        expect_hit("R9", 21, 0);

        for (int i = 0; i < N; i++) cmd("R10", 1, 0, i, i * 'h10, 3);
        check("R10", "fill no capacity", cnt_capacity, 0);
        cmd("R10", 1, 0, 40, 'h9000, 3);
        expect_hit("R10", 0, 0);
        expect_hit("R10", 1, 1);
        cmd("R10", 1, 5, 5, 0, 0);
        cmd("R10", 1, 0, 41, 'h9100, 3);
        check("R10", "refill free slot", cnt_capacity, 1);
        cmd("R10", 1, 0, 42, 'h9200, 3);
        expect_hit("R10", 1, 0);
        expect_hit("R10", 2, 1);
        for (int i = 0; i < 40; i++) cmd("R10", 1, 0, 50 + i, 'hA000 + i * 'h10, 2);
        cmd("R7", 1, 4, 120, 'hF000, 3);
        expect_hit("R7", 120, 1);

        for (int i = 0; i < 2000; i++)
            cmd("R4", 1, $urandom_range(0, 7), $urandom_range(0, 15),
                $urandom_range(0, 63), $urandom_range(0, 7));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule